// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one erase request, given as a byte offset and a byte length, into the series of erase commands that a paged serial flash needs. It does not generate SPI bit timing. It talks to a byte-transfer engine through a start/done handshake, one byte at a time, and it controls a chip-select line that frames each command. For every erase unit it sends a four-byte command and then polls the device's status byte until the device reports ready.

The page size does not have to be a power of two; a 264-byte page is a typical case. Inside the address, the page index sits at a fixed bit position (`PAGE_SHIFT`) that is independent of the page size. Whenever the current page begins an aligned group of eight pages and at least eight pages are still to be erased, the block issues one block erase in place of eight page erases. The request ends with a single-cycle done pulse and an error code. The code reports success, a misaligned request, or a device that stayed busy past the poll timeout.

Top module: `flash_erase_seq`

## Requirements
- R1: When the request is accepted, an offset or a length that is not a whole multiple of `PAGE_BYTES` ends the request. `done` then pulses with `err_code` = 1 and chip select is never asserted.
- R2: A length of zero with an aligned offset ends the request with `err_code` = 0 and no command.
- R3: Each erase command is four bytes sent under one unbroken chip-select assertion. The bytes are, in order: opcode, flash address bits [23:16], flash address bits [15:8], and 0x00. The flash address is the page index (offset / `PAGE_BYTES`) shifted left by `PAGE_SHIFT`.
- R4: Block erase (opcode 0x50) is used when the page index is a multiple of 8 and 8 or more pages remain, and it then advances the position by 8 pages. In every other case page erase (opcode 0x81) is used and the position advances by 1 page.
- R5: After each command, chip select drops for at least one cycle. Polling then begins. Each poll is a separate two-byte frame: 0xD7, then a 0x00 byte whose returned value gives the status. Status bit 7 = 1 means ready, and the other bits are ignored. Chip select drops between polls.
- R6: If the device is still busy at a poll decision made after `TIMEOUT_CYC` cycles counted from the end of the command, the request ends with `err_code` = 2 and no further command is sent.
- R7: `busy` is high from the cycle after acceptance until the done cycle, inclusive. `done` is a single-cycle pulse. On success `err_code` = 0 and the command count matches the units that cover the range.
- R8: A request presented while `busy` is high, including in the done cycle, is ignored and causes no command.
- R9: Only one byte transfer is outstanding at a time. `spi_start` is a single-cycle pulse given only while chip select is asserted, and `spi_tx` holds steady until `spi_done` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Erase request strobe, taken when idle |
| req_offset | input | ADDR_W | Byte offset of the first byte to erase |
| req_len | input | ADDR_W | Number of bytes to erase |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 misaligned, 2 timeout; valid with done |
| spi_cs | output | 1 | Chip select, active high, framing each command or poll |
| spi_start | output | 1 | Launch one byte transfer |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Byte transfer finished |
| spi_rx | input | 8 | Byte received, valid with spi_done |

## Verification
The end of one request and the arrival of the next request can land in the same cycle. To provoke this, the bench raises a new, valid request exactly in the cycle where `done` is high, while the sequencer is still busy. It judges the result by watching chip select for a long window afterwards: the select must stay low, and no command may reach the scoreboard. The bench also places a request in the middle of a multi-unit erase. After that, the only commands seen must be the ones the first request expected.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS_RD   = 8'hD7;
  localparam logic [7:0] FILL_BYTE      = 8'h00;
  localparam int unsigned CMD_BYTES     = 4;
  localparam int unsigned POLL_BYTES    = 2;
  localparam int unsigned GROUP_PAGES   = 8;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ALIGN   = 2'd1,
    ERR_TIMEOUT = 2'd2
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP_CMD,
    ST_POLL,
    ST_GAP_POLL,
    ST_FIN
  } state_e;
endpackage

// File: rtl/fes_unit_plan.sv
module fes_unit_plan
  import fes_pkg::*;
#(
  parameter int unsigned PG_W        = 24,
  parameter int unsigned PAGE_SHIFT  = 9,
  parameter bit          ALLOW_BLOCK = 1'b1
) (
  input  logic [PG_W-1:0] page_idx,
  input  logic [PG_W-1:0] rem_pages,
  output logic            use_block,
  output logic [7:0]      opcode,
  output logic [15:0]     addr_upper,
  output logic [PG_W-1:0] step
);
  localparam int unsigned GRP_LOG = $clog2(GROUP_PAGES);

  generate
    if (ALLOW_BLOCK) begin : g_block
      assign use_block = (page_idx[GRP_LOG-1:0] == '0) &&
                         (rem_pages >= PG_W'(GROUP_PAGES));
    end else begin : g_page_only
      assign use_block = 1'b0;
    end
  endgenerate

  assign opcode     = use_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
  assign step       = use_block ? PG_W'(GROUP_PAGES) : PG_W'(1);
  assign addr_upper = 16'(page_idx << (PAGE_SHIFT - 8));
endmodule

// File: rtl/fes_poll_timer.sv
module fes_poll_timer #(
  parameter int unsigned TIMEOUT_CYC = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = TW'(TIMEOUT_CYC);
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  assert_timer_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && expired) |=> expired);
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_BYTES = 264
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [ADDR_W-1:0] req_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic              spi_cs,
  output logic              spi_start,
  output logic [7:0]        spi_tx,
  input  logic              spi_done,
  input  logic              spi_rdy_bit,
  output logic [ADDR_W-1:0] page_idx,
  output logic [ADDR_W-1:0] rem_pages,
  input  logic [7:0]        plan_opcode,
  input  logic [15:0]       plan_addr,
  input  logic [ADDR_W-1:0] plan_step,
  output logic              tmr_load,
  output logic              tmr_run,
  input  logic              tmr_expired
);
  localparam logic [ADDR_W-1:0] PB       = ADDR_W'(PAGE_BYTES);
  localparam logic [1:0]        CMD_LAST = 2'(CMD_BYTES - 1);
  localparam logic [1:0]        POLL_LAST = 2'(POLL_BYTES - 1);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] page_q, page_d, rem_q, rem_d;
  logic              pos_en;
  logic [1:0]        byte_q, byte_d;
  logic              pend_q, pend_d;
  logic              rdy_q, rdy_d;
  err_e              err_q, err_d;
  logic              off_mis, len_mis;
  logic [ADDR_W-1:0] off_pages, len_pages;

  assign off_mis   = (req_offset % PB) != '0;
  assign len_mis   = (req_len % PB) != '0;
  assign off_pages = req_offset / PB;
  assign len_pages = req_len / PB;

  always_comb begin
    state_d   = state_q;
    page_d    = page_q;
    rem_d     = rem_q;
    pos_en    = 1'b0;
    byte_d    = byte_q;
    pend_d    = pend_q;
    rdy_d     = rdy_q;
    err_d     = err_q;
    spi_start = 1'b0;
    tmr_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          byte_d = '0;
          pend_d = 1'b0;
          if (off_mis || len_mis) begin
            err_d   = ERR_ALIGN;
            state_d = ST_FIN;
          end else begin
            err_d   = ERR_NONE;
            pos_en  = 1'b1;
            page_d  = off_pages;
            rem_d   = len_pages;
            state_d = (len_pages == '0) ? ST_FIN : ST_CMD;
          end
        end
      end
      ST_CMD: begin
        if (!pend_q) begin
          spi_start = 1'b1;
          pend_d    = 1'b1;
        end else if (spi_done) begin
          pend_d = 1'b0;
          if (byte_q == CMD_LAST) begin
            byte_d   = '0;
            tmr_load = 1'b1;
            state_d  = ST_GAP_CMD;
          end else begin
            byte_d = byte_q + 1'b1;
          end
        end
      end
      ST_GAP_CMD: state_d = ST_POLL;
      ST_POLL: begin
        if (!pend_q) begin
          spi_start = 1'b1;
          pend_d    = 1'b1;
        end else if (spi_done) begin
          pend_d = 1'b0;
          if (byte_q == POLL_LAST) begin
            byte_d  = '0;
            rdy_d   = spi_rdy_bit;
            state_d = ST_GAP_POLL;
          end else begin
            byte_d = byte_q + 1'b1;
          end
        end
      end
      ST_GAP_POLL: begin
        if (rdy_q) begin
          pos_en  = 1'b1;
          page_d  = page_q + plan_step;
          rem_d   = rem_q - plan_step;
          state_d = (rem_q == plan_step) ? ST_FIN : ST_CMD;
        end else if (tmr_expired) begin
          err_d   = ERR_TIMEOUT;
          state_d = ST_FIN;
        end else begin
          state_d = ST_POLL;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      pend_q  <= pend_d;
      rdy_q   <= rdy_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      rem_q  <= '0;
    end else if (pos_en) begin
      page_q <= page_d;
      rem_q  <= rem_d;
    end
  end

  always_comb begin
    spi_tx = FILL_BYTE;
    if (state_q == ST_CMD) begin
      unique case (byte_q)
        2'd0:    spi_tx = plan_opcode;
        2'd1:    spi_tx = plan_addr[15:8];
        2'd2:    spi_tx = plan_addr[7:0];
        default: spi_tx = FILL_BYTE;
      endcase
    end else if (state_q == ST_POLL) begin
      spi_tx = (byte_q == '0) ? OP_STATUS_RD : FILL_BYTE;
    end
  end

  assign spi_cs    = (state_q == ST_CMD) || (state_q == ST_POLL);
  assign tmr_run   = (state_q == ST_GAP_CMD) || (state_q == ST_POLL) ||
                     (state_q == ST_GAP_POLL);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err_code  = err_q;
  assign page_idx  = page_q;
  assign rem_pages = rem_q;

  assert_align_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && req_valid && (off_mis || len_mis))
      |=> (done && !spi_cs && (err_code == ERR_ALIGN)));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_GAP_POLL) && rdy_q)
      |=> ((rem_q == $past(rem_q) - ADDR_W'(1)) ||
           (rem_q == $past(rem_q) - ADDR_W'(GROUP_PAGES))));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (state_q != ST_GAP_POLL) && (state_q != ST_FIN))
      |=> ($stable(page_q) && $stable(rem_q)));

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !spi_done) |=> ($stable(spi_tx) && !spi_start));

  assert_start_in_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> spi_cs);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned PAGE_BYTES  = 264,
  parameter int unsigned PAGE_SHIFT  = 9,
  parameter int unsigned TIMEOUT_CYC = 400_000_000,
  parameter bit          ALLOW_BLOCK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [ADDR_W-1:0] req_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic              spi_cs,
  output logic              spi_start,
  output logic [7:0]        spi_tx,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx
);
  logic              rst_meta, rst_sync_n;
  logic [ADDR_W-1:0] page_idx, rem_pages, plan_step;
  logic [7:0]        plan_opcode;
  logic [15:0]       plan_addr;
  logic              plan_block;
  logic              tmr_load, tmr_run, tmr_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fes_unit_plan #(
    .PG_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ALLOW_BLOCK(ALLOW_BLOCK)
  ) u_plan (
    .page_idx(page_idx), .rem_pages(rem_pages), .use_block(plan_block),
    .opcode(plan_opcode), .addr_upper(plan_addr), .step(plan_step)
  );

  fes_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(tmr_load), .run(tmr_run),
    .expired(tmr_expired)
  );

  fes_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid),
    .req_offset(req_offset), .req_len(req_len), .busy(busy), .done(done),
    .err_code(err_code), .spi_cs(spi_cs), .spi_start(spi_start),
    .spi_tx(spi_tx), .spi_done(spi_done), .spi_rdy_bit(spi_rx[7]),
    .page_idx(page_idx), .rem_pages(rem_pages), .plan_opcode(plan_opcode),
    .plan_addr(plan_addr), .plan_step(plan_step), .tmr_load(tmr_load),
    .tmr_run(tmr_run), .tmr_expired(tmr_expired)
  );

  assert_block_grouping_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (spi_start && (spi_tx == OP_BLOCK_ERASE) && plan_block) |->
      (page_idx[2:0] == 3'd0));
endmodule

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  localparam int unsigned PB = 264;
  localparam int unsigned SH = 9;
  localparam int unsigned TO = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_offset = '0, req_len = '0;
  logic        busy, done, spi_cs, spi_start;
  logic [1:0]  err_code;
  logic [7:0]  spi_tx;
  logic        spi_done = 1'b0;
  logic [7:0]  spi_rx = 8'h00;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.ADDR_W(24), .PAGE_BYTES(PB), .PAGE_SHIFT(SH),
                    .TIMEOUT_CYC(TO)) i_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_len(req_len), .busy(busy), .done(done), .err_code(err_code),
    .spi_cs(spi_cs), .spi_start(spi_start), .spi_tx(spi_tx),
    .spi_done(spi_done), .spi_rx(spi_rx));

  int          n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  int unsigned busy_polls = 0, poll_cnt = 0;
  int          flen = 0, pend_cnt = 0;
  logic [7:0]  fb [0:7];
  logic [7:0]  rx_next = 8'h00;
  logic        cs_prev = 1'b0, cs_any = 1'b0;

  task automatic report(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic end_frame();
    logic [31:0] got, e;
    n_chk++;
    if (flen == 4) begin
      got = {fb[0], fb[1], fb[2], fb[3]};
      poll_cnt = 0;
      if (exp_q.size() == 0) report("R8 unexpected command", got, 32'h0);
      else begin
        e = exp_q.pop_front();
        if (got !== e) report("R3/R4 command frame", got, e);
      end
    end else if (flen == 2) begin
      if (fb[0] !== 8'hD7 || fb[1] !== 8'h00)
        report("R5 poll frame", {16'h0, fb[0], fb[1]}, 32'h0000D700);
      poll_cnt++;
    end else begin
      report("R5 frame length", 32'(flen), 32'd4);
    end
    flen = 0;
  endtask

  // byte engine model and scoreboard monitor, away from the active edge
  always @(negedge clk) begin
    spi_done = 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        spi_done = 1'b1;
        spi_rx   = rx_next;
      end
    end
    if (spi_cs) cs_any = 1'b1;
    if (spi_start) begin
      n_chk++;
      if (!spi_cs || pend_cnt != 0) report("R9 start while busy or deselected", {31'h0, spi_cs}, 32'h1);
      if (flen < 8) fb[flen] = spi_tx;
      rx_next = (flen == 1 && fb[0] == 8'hD7) ?
                ((poll_cnt >= busy_polls) ? 8'h80 : 8'h7F) : 8'h5A;
      flen++;
      pend_cnt = 2;
    end
    if (cs_prev && !spi_cs) end_frame();
    cs_prev = spi_cs;
  end

  task automatic plan_units(input int unsigned off, input int unsigned len,
                            input int unsigned max_units, output int pushed);
    int unsigned pg, rem, a, stepv;
    bit blk;
    pg = off / PB; rem = len / PB; pushed = 0;
    while (rem > 0 && pushed < int'(max_units)) begin
      blk = ((pg % 8) == 0) && (rem >= 8);
      a = pg << SH;
      exp_q.push_back({blk ? 8'h50 : 8'h81, a[23:16], a[15:8], 8'h00});
      stepv = blk ? 8 : 1;
      pg += stepv; rem -= stepv; pushed++;
    end
  endtask

  task automatic run_req(input int unsigned off, input int unsigned len,
                         input int unsigned polls, input int unsigned max_units,
                         input logic [1:0] exp_err, input string tag,
                         input bit mid_req, input bit done_req);
    int pushed, cyc;
    plan_units(off, len, max_units, pushed);
    busy_polls = polls;
    cs_any = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_offset = 24'(off); req_len = 24'(len);
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    if (busy !== 1'b1) report({tag, " R7 busy after accept"}, {31'h0, busy}, 32'h1);
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (mid_req && cyc == 5) begin
        req_valid = 1'b1; req_offset = 24'(PB * 40); req_len = 24'(PB);
      end else req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    n_chk++;
    if (done !== 1'b1 || err_code !== exp_err)
      report({tag, " done/err_code"}, {29'h0, done, err_code}, {29'h0, 1'b1, exp_err});
    if (done_req) begin
      req_valid = 1'b1; req_offset = 24'(PB * 3); req_len = 24'(PB);
    end
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    if (done !== 1'b0) report("R7 done pulse width", {31'h0, done}, 32'h0);
    if (done_req) begin
      cs_any = 1'b0;
      repeat (30) @(negedge clk);
      n_chk++;
      if (cs_any || busy) report("R8 request in done cycle", {30'h0, cs_any, busy}, 32'h0);
    end
    n_chk++;
    if (exp_q.size() != 0) report({tag, " missing commands"}, 32'(exp_q.size()), 32'h0);
    if (pushed == 0) begin
      n_chk++;
      if (cs_any) report({tag, " select without command"}, 32'h1, 32'h0);
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if (busy !== 1'b0 || done !== 1'b0 || spi_cs !== 1'b0 || spi_start !== 1'b0)
      report("R7 reset state", {28'h0, busy, done, spi_cs, spi_start}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4: unaligned start, then block, then page
    run_req(PB * 5, PB * 12, 2, 100, 2'd0, "R4 mixed units", 1'b0, 1'b0);
    // R4: block at boundary followed by two page erases
    run_req(PB * 8, PB * 10, 0, 100, 2'd0, "R4 block first", 1'b0, 1'b0);
    // R4: exactly eight pages at a group start
    run_req(PB * 16, PB * 8, 1, 100, 2'd0, "R4 exact block", 1'b0, 1'b0);
    // R4: seven pages at page zero stay page erases
    run_req(0, PB * 7, 0, 100, 2'd0, "R4 seven pages", 1'b0, 1'b0);
    // R3: high page index exercises address bits 23:16
    run_req(PB * 20000, PB, 3, 100, 2'd0, "R3 high address", 1'b0, 1'b0);
    // R1: misaligned offset, then misaligned length
    run_req(100, PB, 0, 0, 2'd1, "R1 offset", 1'b0, 1'b0);
    run_req(0, PB + 1, 0, 0, 2'd1, "R1 length", 1'b0, 1'b0);
    // R2: zero length
    run_req(PB * 3, 0, 0, 0, 2'd0, "R2 zero length", 1'b0, 1'b0);
    // R6: device never ready
    run_req(PB * 2, PB * 4, 100000, 1, 2'd2, "R6 timeout", 1'b0, 1'b0);
    // R8: request in mid-erase, and request in the done cycle
    run_req(PB * 9, PB * 3, 1, 100, 2'd0, "R8 mid request", 1'b1, 1'b1);
    // R5 and R6: recovery after timeout with slow but ready device
    run_req(PB * 24, PB * 2, 4, 100, 2'd0, "R5 slow ready", 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule